// File: doc/BRIEF.md
# Multithreaded Control Register Bank

This block is the set of special-purpose sub-registers that a multithreaded core reaches through its read-control and write-control commands. An access carries a 6-bit sub-register ID and a thread index. Most entries exist once and are seen by every hardware thread. Some exist once per thread, and for those the thread index on the request picks the instance. The bank holds the identity values (tile, core, thread, and a merged global ID) and a 64-bit cycle counter. It also holds a thread-enable mask, per-thread status and trap cause, and cache-miss counters. Per-thread counters record memory-stall cycles and kernel-active cycles. The rest is a write-policy mode bit, a software argument pair, a non-coherent region word and sixteen debug words.

Requests arrive over a valid/ready port. A read produces one response word over a valid/ready response port, one cycle after it is accepted. A write produces no response. The request port is ready whenever the response slot is empty or is being drained in the same cycle. While the response is held by back-pressure, no new request is taken and the response word does not change. Event inputs (cache misses, per-thread stalls, kernel activity, traps) are sampled on every clock. The write-policy bit, the enable mask and every thread's status are driven out to the rest of the core.

Top module: `ctl_regbank`

## Requirements
- R1: After reset every thread status is IDLE (0), trap causes and all counters are zero, the write-policy output and the enable mask are 0, and no response is pending.
- R2: Reads of ID 0 and ID 1 return the tile and core ID inputs. ID 2 returns the request's thread index. ID 3 returns the global ID: tile in bits [19:12], core in [11:4], thread index in [3:0]. ID 14 returns the thread count, 8.
- R3: ID 4 returns the low 32 bits of a counter that starts at 0 on the first clock after reset and advances by one each clock. Each accepted read of ID 4 captures the counter's upper 32 bits, and ID 5 returns that captured value.
- R4: ID 7 and ID 8 return the number of clocks during which the data-miss input and the instruction-miss input were high.
- R5: ID 15 and ID 16 return, for the selected thread, the number of clocks during which its stall input and its kernel-active input were high.
- R6: A write to ID 11 sets the selected thread's status when the written word is 0 to 4, and is ignored otherwise. Thread t's status appears on thread_status_o bits [3t+2:3t], and ID 11 reads it back.
- R7: A trap pulse on a thread sets its status to TRAPPED (3). The same pulse sets its cause, read at ID 10, to 1 for a scratchpad misalignment (trap_ldst_i low) or 2 for a load/store-unit misalignment (trap_ldst_i high). A trap wins over a status write to the same thread in the same cycle.
- R8: A write to ID 17 stores bit 0 of the word as the write-policy bit. That bit drives write_through_o (1 = write-through, 0 = write-back), and a read of ID 17 returns it with all other bits zero.
- R9: ID 6 is a read/write 8-bit thread-enable mask that drives thread_en_o. IDs 12, 13 and 19 are full 32-bit read/write words.
- R10: IDs 20 to 35 are sixteen independent 32-bit debug words. ID 20+k reads back the last value written to ID 20+k.
- R11: Writes to the read-only IDs (0-5, 7-10, 14-16) and to unused IDs (18, 36-63) change nothing. Reads of unused IDs return 0.
- R12: A request is accepted when req_valid and req_ready are both high. req_ready is high exactly when rsp_valid is low or rsp_ready is high. An accepted read raises rsp_valid on the next cycle with its data. While rsp_valid is high and rsp_ready is low, the data is held. Writes never raise rsp_valid.
- R13: ID 9 returns the selected thread's program-counter input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_id_i | input | 8 | Tile identity |
| core_id_i | input | 8 | Core identity |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | 6 | Sub-register ID |
| req_thread | input | 3 | Thread index for per-thread entries |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response can be consumed |
| rsp_rdata | output | 32 | Read response data |
| pc_i | input | 256 | Per-thread PC, thread t in bits [32t+31:32t] |
| miss_data_i | input | 1 | Data-cache miss event |
| miss_instr_i | input | 1 | Instruction-cache miss event |
| stall_i | input | 8 | Per-thread memory stall |
| kernel_i | input | 8 | Per-thread kernel active |
| trap_i | input | 8 | Per-thread trap pulse |
| trap_ldst_i | input | 8 | Per-thread trap origin: 1 load/store unit, 0 scratchpad |
| write_through_o | output | 1 | Cache write-policy bit |
| thread_en_o | output | 8 | Thread-enable mask |
| thread_status_o | output | 24 | Per-thread status, 3 bits each |

## Verification
Two pairs of functions can fall in one cycle. The first is a software status write and a trap pulse on the same thread. The bench forces a trap on thread 3 in the very cycle that a write of RUNNING to that thread is accepted, and it expects TRAPPED with the trap's cause. The second is an accepted read and back-pressure on the response slot. Random rsp_ready stalls keep the slot full while requests wait, and a behavioural model predicts req_ready, rsp_valid and the held response word on every clock. Counter reads also meet counter increments in the same edge, and the model expects the value from before that edge.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int unsigned ID_W = 6;

  typedef enum logic [2:0] {
    TS_IDLE    = 3'd0,
    TS_RUN     = 3'd1,
    TS_DONE    = 3'd2,
    TS_TRAP    = 3'd3,
    TS_BARRIER = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    TC_NONE = 2'd0,
    TC_SPAD = 2'd1,
    TC_LDST = 2'd2
  } trap_cause_e;

  localparam logic [ID_W-1:0] A_TILE   = 6'd0;
  localparam logic [ID_W-1:0] A_CORE   = 6'd1;
  localparam logic [ID_W-1:0] A_TID    = 6'd2;
  localparam logic [ID_W-1:0] A_GID    = 6'd3;
  localparam logic [ID_W-1:0] A_CNTLO  = 6'd4;
  localparam logic [ID_W-1:0] A_CNTHI  = 6'd5;
  localparam logic [ID_W-1:0] A_TEN    = 6'd6;
  localparam logic [ID_W-1:0] A_MISSD  = 6'd7;
  localparam logic [ID_W-1:0] A_MISSI  = 6'd8;
  localparam logic [ID_W-1:0] A_PC     = 6'd9;
  localparam logic [ID_W-1:0] A_CAUSE  = 6'd10;
  localparam logic [ID_W-1:0] A_STATUS = 6'd11;
  localparam logic [ID_W-1:0] A_ARG0   = 6'd12;
  localparam logic [ID_W-1:0] A_ARG1   = 6'd13;
  localparam logic [ID_W-1:0] A_NTHR   = 6'd14;
  localparam logic [ID_W-1:0] A_STALL  = 6'd15;
  localparam logic [ID_W-1:0] A_KERN   = 6'd16;
  localparam logic [ID_W-1:0] A_POLICY = 6'd17;
  localparam logic [ID_W-1:0] A_NCMAP  = 6'd19;
endpackage

// File: rtl/ctl_cycle_counter.sv
module ctl_cycle_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap,
  output logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] hi_snap
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (snap) hi_q <= cnt_q[CNT_W-1:DATA_W];
    end
  end

  assign lo      = cnt_q[DATA_W-1:0];
  assign hi_snap = hi_q;
endmodule

// File: rtl/ctl_thread_slice.sv
module ctl_thread_slice
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_we,
  input  thr_state_e        st_wval,
  input  logic              trap_ev,
  input  logic              trap_ldst,
  input  logic              stall_ev,
  input  logic              kern_ev,
  output thr_state_e        state,
  output trap_cause_e       cause,
  output logic [DATA_W-1:0] stall_cnt,
  output logic [DATA_W-1:0] kern_cnt
);
  // A trap outranks a same-cycle software status write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TS_IDLE;
      cause <= TC_NONE;
    end else if (trap_ev) begin
      state <= TS_TRAP;
      cause <= trap_ldst ? TC_LDST : TC_SPAD;
    end else if (st_we) begin
      state <= st_wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      kern_cnt  <= '0;
    end else begin
      if (stall_ev) stall_cnt <= stall_cnt + DATA_W'(1);
      if (kern_ev)  kern_cnt  <= kern_cnt + DATA_W'(1);
    end
  end
endmodule

// File: rtl/ctl_shared_regs.sv
module ctl_shared_regs
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned NUM_DBG     = 16,
  parameter int unsigned DBG_BASE    = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ID_W-1:0]        wr_id,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   miss_d,
  input  logic                   miss_i,
  input  logic [ID_W-1:0]        rd_id,
  output logic                   rd_hit,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NUM_THREADS-1:0] thread_en,
  output logic                   write_through
);
  localparam int unsigned DBG_IDX_W = $clog2(NUM_DBG);
  localparam logic [ID_W-1:0] DBG_LO = ID_W'(DBG_BASE);
  localparam logic [ID_W-1:0] DBG_HI = ID_W'(DBG_BASE + NUM_DBG - 1);

  logic [DATA_W-1:0] arg0_q, arg1_q, ncmap_q, missd_q, missi_q;
  logic [DATA_W-1:0] dbg_q [NUM_DBG];
  logic [DBG_IDX_W-1:0] dbg_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thread_en     <= '0;
      write_through <= 1'b0;
      arg0_q        <= '0;
      arg1_q        <= '0;
      ncmap_q       <= '0;
    end else if (wr_en) begin
      case (wr_id)
        A_TEN:    thread_en     <= wr_data[NUM_THREADS-1:0];
        A_POLICY: write_through <= wr_data[0];
        A_ARG0:   arg0_q        <= wr_data;
        A_ARG1:   arg1_q        <= wr_data;
        A_NCMAP:  ncmap_q       <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      missd_q <= '0;
      missi_q <= '0;
    end else begin
      if (miss_d) missd_q <= missd_q + DATA_W'(1);
      if (miss_i) missi_q <= missi_q + DATA_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_DBG; g++) begin : g_dbg
    localparam logic [ID_W-1:0] MY_ID = ID_W'(DBG_BASE + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       dbg_q[g] <= '0;
      else if (wr_en && wr_id == MY_ID) dbg_q[g] <= wr_data;
    end
  end

  assign dbg_idx = DBG_IDX_W'(rd_id - DBG_LO);

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    if (rd_id >= DBG_LO && rd_id <= DBG_HI) begin
      rd_data = dbg_q[dbg_idx];
    end else begin
      case (rd_id)
        A_TEN:    rd_data = DATA_W'(thread_en);
        A_POLICY: rd_data = DATA_W'(write_through);
        A_ARG0:   rd_data = arg0_q;
        A_ARG1:   rd_data = arg1_q;
        A_NCMAP:  rd_data = ncmap_q;
        A_MISSD:  rd_data = missd_q;
        A_MISSI:  rd_data = missi_q;
        default:  rd_hit  = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned TILE_W      = 8,
  parameter int unsigned CORE_W      = 8,
  parameter int unsigned TID_W       = 4,
  parameter int unsigned NUM_DBG     = 16,
  parameter int unsigned DBG_BASE    = 20,
  localparam int unsigned TIDX_W     = $clog2(NUM_THREADS),
  localparam int unsigned ST_W       = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TILE_W-1:0]             tile_id_i,
  input  logic [CORE_W-1:0]             core_id_i,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ID_W-1:0]               req_id,
  input  logic [TIDX_W-1:0]             req_thread,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_rdata,
  input  logic [NUM_THREADS*DATA_W-1:0] pc_i,
  input  logic                          miss_data_i,
  input  logic                          miss_instr_i,
  input  logic [NUM_THREADS-1:0]        stall_i,
  input  logic [NUM_THREADS-1:0]        kernel_i,
  input  logic [NUM_THREADS-1:0]        trap_i,
  input  logic [NUM_THREADS-1:0]        trap_ldst_i,
  output logic                          write_through_o,
  output logic [NUM_THREADS-1:0]        thread_en_o,
  output logic [NUM_THREADS*ST_W-1:0]   thread_status_o
);
  logic wr_acc, rd_acc, st_legal;
  logic sh_hit;
  logic [DATA_W-1:0] sh_data, cnt_lo, cnt_hi, rd_val;

  thr_state_e        st_a    [NUM_THREADS];
  trap_cause_e       cause_a [NUM_THREADS];
  logic [DATA_W-1:0] stall_a [NUM_THREADS];
  logic [DATA_W-1:0] kern_a  [NUM_THREADS];
  logic [DATA_W-1:0] pc_a    [NUM_THREADS];

  assign req_ready = !rsp_valid || rsp_ready;
  assign wr_acc    = req_valid && req_ready && req_write;
  assign rd_acc    = req_valid && req_ready && !req_write;
  assign st_legal  = (req_wdata[DATA_W-1:ST_W] == '0) && (req_wdata[ST_W-1:0] <= 3'd4);

  ctl_cycle_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap    (rd_acc && req_id == A_CNTLO),
    .lo      (cnt_lo),
    .hi_snap (cnt_hi)
  );

  ctl_shared_regs #(
    .DATA_W(DATA_W), .NUM_THREADS(NUM_THREADS),
    .NUM_DBG(NUM_DBG), .DBG_BASE(DBG_BASE)
  ) u_shared (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_acc),
    .wr_id         (req_id),
    .wr_data       (req_wdata),
    .miss_d        (miss_data_i),
    .miss_i        (miss_instr_i),
    .rd_id         (req_id),
    .rd_hit        (sh_hit),
    .rd_data       (sh_data),
    .thread_en     (thread_en_o),
    .write_through (write_through_o)
  );

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    logic we;
    assign we = wr_acc && (req_id == A_STATUS) && st_legal &&
                (req_thread == TIDX_W'(g));
    assign pc_a[g] = pc_i[g*DATA_W +: DATA_W];

    ctl_thread_slice #(.DATA_W(DATA_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_we     (we),
      .st_wval   (thr_state_e'(req_wdata[ST_W-1:0])),
      .trap_ev   (trap_i[g]),
      .trap_ldst (trap_ldst_i[g]),
      .stall_ev  (stall_i[g]),
      .kern_ev   (kernel_i[g]),
      .state     (st_a[g]),
      .cause     (cause_a[g]),
      .stall_cnt (stall_a[g]),
      .kern_cnt  (kern_a[g])
    );

    assign thread_status_o[g*ST_W +: ST_W] = st_a[g];
  end

  always_comb begin
    rd_val = '0;
    if (sh_hit) begin
      rd_val = sh_data;
    end else begin
      case (req_id)
        A_TILE:   rd_val = DATA_W'(tile_id_i);
        A_CORE:   rd_val = DATA_W'(core_id_i);
        A_TID:    rd_val = DATA_W'(req_thread);
        A_GID:    rd_val = DATA_W'({tile_id_i, core_id_i, TID_W'(req_thread)});
        A_CNTLO:  rd_val = cnt_lo;
        A_CNTHI:  rd_val = cnt_hi;
        A_PC:     rd_val = pc_a[req_thread];
        A_CAUSE:  rd_val = DATA_W'(cause_a[req_thread]);
        A_STATUS: rd_val = DATA_W'(st_a[req_thread]);
        A_NTHR:   rd_val = DATA_W'(NUM_THREADS);
        A_STALL:  rd_val = stall_a[req_thread];
        A_KERN:   rd_val = kern_a[req_thread];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_regbank_checker.sv
module ctl_regbank_checker #(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned DATA_W      = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic                        req_write,
  input logic [5:0]                  req_id,
  input logic                        wdata_b0,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic [DATA_W-1:0]           rsp_rdata,
  input logic [NUM_THREADS-1:0]      trap_i,
  input logic [NUM_THREADS*3-1:0]    thread_status_o,
  input logic                        write_through_o
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (thread_status_o == '0 && !rsp_valid && !write_through_o));

  assert_stall_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_policy_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_id == 6'd17) |=>
      (write_through_o == $past(wdata_b0)));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    assert_status_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      thread_status_o[t*3 +: 3] <= 3'd4);

    assert_trap_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i[t] |=> (thread_status_o[t*3 +: 3] == 3'd3));
  end
endmodule

bind ctl_regbank ctl_regbank_checker #(.NUM_THREADS(NUM_THREADS), .DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_write       (req_write),
  .req_id          (req_id),
  .wdata_b0        (req_wdata[0]),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_rdata       (rsp_rdata),
  .trap_i          (trap_i),
  .thread_status_o (thread_status_o),
  .write_through_o (write_through_o)
);

// File: tb/ctl_regbank_bench.sv
module ctl_regbank_bench;
  localparam int NT = 8;
  localparam logic [7:0] TILE = 8'hA5;
  localparam logic [7:0] CORE = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [5:0] req_id = '0;
  logic [2:0] req_thread = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, write_through_o;
  logic [31:0] rsp_rdata;
  logic [NT*32-1:0] pc_i = '0;
  logic miss_data_i = 1'b0, miss_instr_i = 1'b0;
  logic [NT-1:0] stall_i = '0, kernel_i = '0, trap_i = '0, trap_ldst_i = '0;
  logic [NT-1:0] thread_en_o;
  logic [NT*3-1:0] thread_status_o;

  always #10 clk = ~clk;

  ctl_regbank u_ctl_regbank (
    .clk(clk), .rst_n(rst_n), .tile_id_i(TILE), .core_id_i(CORE),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_id(req_id), .req_thread(req_thread), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pc_i(pc_i), .miss_data_i(miss_data_i), .miss_instr_i(miss_instr_i),
    .stall_i(stall_i), .kernel_i(kernel_i), .trap_i(trap_i),
    .trap_ldst_i(trap_ldst_i), .write_through_o(write_through_o),
    .thread_en_o(thread_en_o), .thread_status_o(thread_status_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint unsigned m_cnt;
  logic [31:0] m_hi, m_md, m_mi, m_arg0, m_arg1, m_map;
  logic [7:0]  m_ten;
  logic        m_wt;
  logic [31:0] m_dbg [16];
  logic [2:0]  m_st [NT];
  logic [1:0]  m_cause [NT];
  logic [31:0] m_stc [NT];
  logic [31:0] m_kc [NT];
  logic        m_rsp_valid, m_acc;
  logic [31:0] m_rsp_data;
  string       m_rsp_tag;
  bit          checking = 0;

  function automatic string tag_of(int id);
    if (id <= 3 || id == 14) return "R2";
    if (id == 4 || id == 5)  return "R3";
    if (id == 7 || id == 8)  return "R4";
    if (id == 15 || id == 16) return "R5";
    if (id == 11) return "R6";
    if (id == 10) return "R7";
    if (id == 17) return "R8";
    if (id == 6 || id == 12 || id == 13 || id == 19) return "R9";
    if (id >= 20 && id <= 35) return "R10";
    if (id == 9) return "R13";
    return "R11";
  endfunction

  function automatic logic [31:0] m_read(int id, int t);
    case (id)
      0:  return 32'(TILE);
      1:  return 32'(CORE);
      2:  return 32'(t);
      3:  return 32'({TILE, CORE, 4'(t)});
      4:  return m_cnt[31:0];
      5:  return m_hi;
      6:  return 32'(m_ten);
      7:  return m_md;
      8:  return m_mi;
      9:  return pc_i[t*32 +: 32];
      10: return 32'(m_cause[t]);
      11: return 32'(m_st[t]);
      12: return m_arg0;
      13: return m_arg1;
      14: return 32'(NT);
      15: return m_stc[t];
      16: return m_kc[t];
      17: return 32'(m_wt);
      19: return m_map;
      default: begin
        if (id >= 20 && id <= 35) return m_dbg[id-20];
        return 32'h0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hi = 0; m_md = 0; m_mi = 0; m_arg0 = 0; m_arg1 = 0;
      m_map = 0; m_ten = 0; m_wt = 0; m_rsp_valid = 0; m_rsp_data = 0;
      m_acc = 0; m_rsp_tag = "R12";
      for (int i = 0; i < 16; i++) m_dbg[i] = 0;
      for (int t = 0; t < NT; t++) begin
        m_st[t] = 0; m_cause[t] = 0; m_stc[t] = 0; m_kc[t] = 0;
      end
    end else begin
      automatic bit rdy = !m_rsp_valid || rsp_ready;
      automatic int id = int'(req_id);
      automatic int t  = int'(req_thread);
      m_acc = req_valid && rdy;
      if (m_acc && !req_write) begin
        m_rsp_data  = m_read(id, t);
        m_rsp_tag   = tag_of(id);
        m_rsp_valid = 1;
        if (id == 4) m_hi = m_cnt[63:32];
      end else if (rsp_ready) begin
        m_rsp_valid = 0;
      end
      if (m_acc && req_write) begin
        case (id)
          6:  m_ten  = req_wdata[7:0];
          11: if (req_wdata <= 32'd4) m_st[t] = req_wdata[2:0];
          12: m_arg0 = req_wdata;
          13: m_arg1 = req_wdata;
          17: m_wt   = req_wdata[0];
          19: m_map  = req_wdata;
          default: if (id >= 20 && id <= 35) m_dbg[id-20] = req_wdata;
        endcase
      end
      for (int k = 0; k < NT; k++) begin
        if (trap_i[k]) begin
          m_st[k] = 3;
          m_cause[k] = trap_ldst_i[k] ? 2'd2 : 2'd1;
        end
        if (stall_i[k])  m_stc[k] = m_stc[k] + 1;
        if (kernel_i[k]) m_kc[k]  = m_kc[k] + 1;
      end
      if (miss_data_i)  m_md = m_md + 1;
      if (miss_instr_i) m_mi = m_mi + 1;
      m_cnt = m_cnt + 1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n && checking) begin
      check("R12 req_ready", 32'(req_ready), 32'(!m_rsp_valid || rsp_ready));
      check("R12 rsp_valid", 32'(rsp_valid), 32'(m_rsp_valid));
      if (m_rsp_valid) check({m_rsp_tag, " rsp_rdata"}, rsp_rdata, m_rsp_data);
      check("R8 write_through_o", 32'(write_through_o), 32'(m_wt));
      check("R9 thread_en_o", 32'(thread_en_o), 32'(m_ten));
      for (int k = 0; k < NT; k++)
        check("R6 R7 thread_status_o", 32'(thread_status_o[k*3 +: 3]), 32'(m_st[k]));
    end
  end

  // ---------------- background event stimulus ----------------
  bit noise = 0;
  logic [NT-1:0] force_trap = '0;

  always @(negedge clk) begin
    if (noise) begin
      miss_data_i  = ($urandom % 4) == 0;
      miss_instr_i = ($urandom % 3) == 0;
      rsp_ready    = ($urandom % 4) != 0;
      for (int k = 0; k < NT; k++) begin
        stall_i[k]     = $urandom % 2;
        kernel_i[k]    = ($urandom % 3) != 0;
        trap_ldst_i[k] = $urandom % 2;
        trap_i[k]      = (($urandom % 900) == 0) || force_trap[k];
        pc_i[k*32 +: 32] = $urandom;
      end
    end else begin
      trap_i = force_trap;
    end
  end

  task automatic issue(bit wr, int id, int thr, logic [31:0] d);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_id     = 6'(id);
    req_thread = 3'(thr);
    req_wdata  = d;
    do @(negedge clk); while (!m_acc);
    req_valid = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 thread_status_o", 32'(thread_status_o), 32'h0);
    check("R1 write_through_o", 32'(write_through_o), 32'h0);
    check("R1 thread_en_o", 32'(thread_en_o), 32'h0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    checking = 1;
    issue(0, 15, 0, 0);   // R1 counters zero / R5
    issue(0, 10, 5, 0);   // R1 cause zero / R7
    noise = 1;

    for (int id = 0; id < 64; id++) issue(0, id, id % NT, 0);

    // shared read/write entries (R8, R9, R10)
    issue(1, 6, 0, 32'hFFFF_FF5A);
    issue(1, 12, 0, 32'h1234_5678);
    issue(1, 13, 0, 32'h8765_4321);
    issue(1, 19, 0, 32'hDEAD_BEEF);
    issue(1, 17, 0, 32'h0000_0003);
    issue(0, 17, 0, 0);
    issue(1, 17, 0, 32'hFFFF_FFFE);
    issue(1, 17, 0, 32'h0000_0001);
    for (int k = 0; k < 16; k++) issue(1, 20 + k, 0, 32'h0101_0101 * k + 32'(k));

    // status writes, legal and illegal (R6)
    issue(1, 11, 2, 1);
    issue(1, 11, 2, 4);
    issue(1, 11, 2, 5);
    issue(1, 11, 2, 32'h1000_0001);
    issue(1, 11, 6, 2);
    issue(0, 11, 2, 0);

    // trap and status write together on thread 3 (R7)
    force_trap = 8'b0000_1000;
    issue(1, 11, 3, 1);
    force_trap = '0;
    issue(0, 11, 3, 0);
    issue(0, 10, 3, 0);

    // writes to read-only and unused IDs (R11)
    for (int id = 0; id < 64; id++) begin
      if (id <= 5 || (id >= 7 && id <= 10) || (id >= 14 && id <= 16) || id == 18 || id >= 36)
        issue(1, id, id % NT, 32'hFFFF_FFFF);
    end

    // full sweep per thread
    for (int t = 0; t < NT; t++)
      for (int id = 0; id < 64; id++) issue(0, id, t, 0);

    // counter pair (R3)
    issue(0, 4, 0, 0);
    issue(0, 5, 0, 0);
    repeat (300) @(negedge clk);
    issue(0, 4, 1, 0);
    issue(0, 5, 1, 0);
    for (int id = 0; id < 40; id++) issue(0, id, 7 - (id % NT), 0);

    noise = 0;
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule